// File: doc/BRIEF.md
# Bus-Master Interrupt Generator

This block turns the completion and error events of a bus-master DMA engine into a single interrupt request. Four event pulses feed it: the read transfer count reaching zero, the write transfer count reaching zero, a target abort, and a master abort. Each pulse latches a sticky pending flag. A configuration register holds one enable per source and a mode bit. A combined request is raised while any enabled source is pending.

The two abort sources are gated. They can raise the request only while at least one of the two transfer-count enables is set. The request is driven onto one of two active-low lines. The host-side line is used when the host started the mastering, and the local-side line is used when the local side started it.

Software reads the pending flags through the status output and clears them by writing ones to the status register.

Top module: `bm_irq_gen`

## Requirements
- R1: After reset the pending flags (`pend_o`) and the configuration (`cfg_o`) read zero, and both `host_irq_no` and `local_irq_no` are high.
- R2: A one-cycle event pulse sets its pending flag at the clock edge that samples it, whether or not the source is enabled. The flags are bit 0 for read count zero, bit 1 for write count zero, bit 2 for target abort and bit 3 for master abort.
- R3: A pending flag stays set, with no further events, until it is cleared.
- R4: A status write (`clr_we_i`) clears each pending flag whose bit in `clr_wdata_i` is one, and leaves flags written with zero unchanged.
- R5: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: The request line asserts at the same edge at which a pending transfer-count flag (bit 0 or 1) and its enable are both set. Configuration bits 0 to 3 enable sources 0 to 3.
- R7: An abort flag (bit 2 or 3) raises the request only if its own enable is set and configuration bit 0 or bit 1 is also set.
- R8: With configuration bit 4 clear (host-initiated mode), the request drives `host_irq_no` low and `local_irq_no` stays high. With bit 4 set (local-initiated mode), it drives `local_irq_no` low and `host_irq_no` stays high.
- R9: The active line returns high at the same edge at which no enabled pending source remains, whether that happens by a clear or by an enable being dropped.
- R10: A configuration write (`cfg_we_i`) loads all five bits, and `cfg_o` reads them back from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_zero_i | input | 1 | Pulse: read transfer count reached zero |
| wr_zero_i | input | 1 | Pulse: write transfer count reached zero |
| tgt_abort_i | input | 1 | Pulse: target abort seen during mastering |
| mst_abort_i | input | 1 | Pulse: master abort seen during mastering |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Enables [3:0], mode [4] |
| clr_we_i | input | 1 | Status write strobe (write one to clear) |
| clr_wdata_i | input | 4 | Clear mask, one bit per source |
| cfg_o | output | 5 | Configuration readback |
| pend_o | output | 4 | Pending source flags |
| host_irq_no | output | 1 | Host-side interrupt, active low |
| local_irq_no | output | 1 | Local-side interrupt, active low |

## Verification
The assertions assume that each event input is a single-cycle pulse sampled on the clock. They also assume that configuration writes and status writes are independent strobes, which may coincide with events but never with reset release. The directed stimulus drives every input one time unit after the rising edge and holds each pulse for exactly one cycle. It aligns collisions deliberately in a single cycle, so that the set-over-clear rule and the same-edge output updates can be sampled right after the edge that should produce them.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
  localparam int NUM_SRC  = 4;
  localparam int CFG_W    = NUM_SRC + 1;
  localparam int SRC_RD   = 0;
  localparam int SRC_WR   = 1;
  localparam int SRC_TABT = 2;
  localparam int SRC_MABT = 3;
  localparam int MODE_BIT = NUM_SRC;

  typedef enum logic {
    MODE_HOST  = 1'b0,
    MODE_LOCAL = 1'b1
  } bm_mode_e;
endpackage

// File: rtl/bmi_pend_bit.sv
module bmi_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic d_o
);
  logic q_q;

  // event beats clear
  assign d_o = set_i | (q_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= d_o;
  end

  assign q_o = q_q;

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/bmi_cfg_reg.sv
module bmi_cfg_reg
  import bmi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [NUM_SRC-1:0] eff_en_d_o,
  output bm_mode_e         mode_d_o
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cnt_en_any;

  assign cfg_d = we_i ? wdata_i : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cnt_en_any = cfg_d[SRC_RD] | cfg_d[SRC_WR];

  // abort sources qualified by any transfer-count enable
  always_comb begin
    eff_en_d_o           = cfg_d[NUM_SRC-1:0];
    eff_en_d_o[SRC_TABT] = cfg_d[SRC_TABT] & cnt_en_any;
    eff_en_d_o[SRC_MABT] = cfg_d[SRC_MABT] & cnt_en_any;
  end

  assign mode_d_o = bm_mode_e'(cfg_d[MODE_BIT]);
  assign cfg_o    = cfg_q;

  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_o == $past(wdata_i)));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/bmi_irq_out.sv
module bmi_irq_out
  import bmi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_d_i,
  input  logic [NUM_SRC-1:0] eff_en_d_i,
  input  bm_mode_e           mode_d_i,
  output logic               host_irq_no,
  output logic               local_irq_no
);
  logic req_q, host_q, local_q;
  logic req_d;

  assign req_d = |(pend_d_i & eff_en_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      host_q  <= 1'b1;
      local_q <= 1'b1;
    end else begin
      req_q   <= req_d;
      host_q  <= ~(req_d & (mode_d_i == MODE_HOST));
      local_q <= ~(req_d & (mode_d_i == MODE_LOCAL));
    end
  end

  assign host_irq_no  = host_q;
  assign local_irq_no = local_q;

  a_r8_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~host_irq_no, ~local_irq_no}));
  a_r9_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q |-> (host_irq_no && local_irq_no));
endmodule

// File: rtl/bm_irq_gen.sv
module bm_irq_gen
  import bmi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_zero_i,
  input  logic               wr_zero_i,
  input  logic               tgt_abort_i,
  input  logic               mst_abort_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_wdata_i,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               host_irq_no,
  output logic               local_irq_no
);
  logic [NUM_SRC-1:0] ev, clr, pend_d, eff_en_d;
  bm_mode_e           mode_d;

  always_comb begin
    ev           = '0;
    ev[SRC_RD]   = rd_zero_i;
    ev[SRC_WR]   = wr_zero_i;
    ev[SRC_TABT] = tgt_abort_i;
    ev[SRC_MABT] = mst_abort_i;
  end

  assign clr = clr_we_i ? clr_wdata_i : '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    bmi_pend_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev[g]),
      .clr_i  (clr[g]),
      .q_o    (pend_o[g]),
      .d_o    (pend_d[g])
    );
  end

  bmi_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .cfg_o      (cfg_o),
    .eff_en_d_o (eff_en_d),
    .mode_d_o   (mode_d)
  );

  bmi_irq_out u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_d_i     (pend_d),
    .eff_en_d_i   (eff_en_d),
    .mode_d_i     (mode_d),
    .host_irq_no  (host_irq_no),
    .local_irq_no (local_irq_no)
  );

  a_r2_rd_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_zero_i |=> pend_o[SRC_RD]);
  a_r7_abort_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[SRC_RD] == 1'b0 && cfg_o[SRC_WR] == 1'b0) |-> (host_irq_no && local_irq_no));
  a_r6_cnt_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[SRC_RD] && cfg_o[SRC_RD]) |-> !(host_irq_no && local_irq_no));
endmodule

// File: tb/sim_bm_irq_gen.sv
module sim_bm_irq_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_zero_i = 0, wr_zero_i = 0, tgt_abort_i = 0, mst_abort_i = 0;
  logic       cfg_we_i = 0, clr_we_i = 0;
  logic [4:0] cfg_wdata_i = '0;
  logic [3:0] clr_wdata_i = '0;
  logic [4:0] cfg_o;
  logic [3:0] pend_o;
  logic       host_irq_no, local_irq_no;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  bm_irq_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_zero_i(rd_zero_i), .wr_zero_i(wr_zero_i),
    .tgt_abort_i(tgt_abort_i), .mst_abort_i(mst_abort_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
    .cfg_o(cfg_o), .pend_o(pend_o),
    .host_irq_no(host_irq_no), .local_irq_no(local_irq_no)
  );

  task automatic tick;
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lines(input string req, input logic h, input logic l);
    check({req, " host"}, {31'd0, host_irq_no}, {31'd0, h});
    check({req, " local"}, {31'd0, local_irq_no}, {31'd0, l});
  endtask

  // drive events and/or clear in the same cycle
  task automatic cycle(input logic [3:0] ev, input logic cw, input logic [3:0] cm);
    {mst_abort_i, tgt_abort_i, wr_zero_i, rd_zero_i} = ev;
    clr_we_i = cw; clr_wdata_i = cm;
    tick;
    {mst_abort_i, tgt_abort_i, wr_zero_i, rd_zero_i} = '0;
    clr_we_i = 0; clr_wdata_i = '0;
  endtask

  task automatic fire(input logic [3:0] ev);
    cycle(ev, 1'b0, 4'h0);
  endtask

  task automatic wclr(input logic [3:0] m);
    cycle(4'h0, 1'b1, m);
  endtask

  task automatic wcfg(input logic [4:0] d);
    cfg_we_i = 1; cfg_wdata_i = d;
    tick;
    cfg_we_i = 0; cfg_wdata_i = '0;
  endtask

  task automatic t_reset;
    check("R1 pend", {28'd0, pend_o}, 32'h0);
    check("R1 cfg", {27'd0, cfg_o}, 32'h0);
    lines("R1", 1'b1, 1'b1);
  endtask

  task automatic t_set_sticky;
    fire(4'b0001);
    check("R2 rd set", {28'd0, pend_o}, 32'h1);
    lines("R2 disabled", 1'b1, 1'b1);
    tick; tick; tick;
    check("R3 sticky", {28'd0, pend_o}, 32'h1);
    fire(4'b0010); fire(4'b0100); fire(4'b1000);
    check("R2 all set", {28'd0, pend_o}, 32'hF);
    wclr(4'hF);
  endtask

  task automatic t_clear;
    fire(4'hF);
    wclr(4'b0101);
    check("R4 partial", {28'd0, pend_o}, 32'hA);
    wclr(4'b0000);
    check("R4 zero mask", {28'd0, pend_o}, 32'hA);
    wclr(4'b1010);
    check("R4 rest", {28'd0, pend_o}, 32'h0);
  endtask

  task automatic t_collision;
    cycle(4'b0001, 1'b1, 4'b0001);
    check("R5 set wins", {28'd0, pend_o}, 32'h1);
    fire(4'b0100);
    cycle(4'b0100, 1'b1, 4'b0101);
    check("R5 mixed", {28'd0, pend_o}, 32'h4);
    wclr(4'hF);
  endtask

  task automatic t_count_irq;
    wcfg(5'b00001);
    check("R10 cfg", {27'd0, cfg_o}, 32'h01);
    lines("R6 nothing pending", 1'b1, 1'b1);
    fire(4'b0010);
    lines("R6 wr not enabled", 1'b1, 1'b1);
    fire(4'b0001);
    lines("R6 rd fires", 1'b0, 1'b1);
    wclr(4'b0001);
    lines("R9 clear deasserts", 1'b1, 1'b1);
    wcfg(5'b00010);
    lines("R6 wr enable", 1'b0, 1'b1);
    wclr(4'hF);
    lines("R9 cleared", 1'b1, 1'b1);
  endtask

  task automatic t_abort_gate;
    wcfg(5'b01100);
    fire(4'b0100);
    check("R7 pend", {28'd0, pend_o}, 32'h4);
    lines("R7 gated", 1'b1, 1'b1);
    wcfg(5'b01110);
    lines("R7 opened by wr_en", 1'b0, 1'b1);
    wcfg(5'b01100);
    lines("R9 enable dropped", 1'b1, 1'b1);
    wclr(4'hF);
    wcfg(5'b01001);
    fire(4'b1000);
    lines("R7 mabt with rd_en", 1'b0, 1'b1);
    wcfg(5'b00001);
    lines("R7 own enable off", 1'b1, 1'b1);
    wclr(4'hF);
  endtask

  task automatic t_mode;
    wcfg(5'b10001);
    check("R10 mode cfg", {27'd0, cfg_o}, 32'h11);
    fire(4'b0001);
    lines("R8 local mode", 1'b1, 1'b0);
    wcfg(5'b00001);
    lines("R8 host mode", 1'b0, 1'b1);
    wcfg(5'b10001);
    lines("R8 back to local", 1'b1, 1'b0);
    wclr(4'h1);
    lines("R9 local release", 1'b1, 1'b1);
  endtask

  initial begin : watchdog
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick; tick;
    rst_ni = 1'b1;
    tick;
    t_reset;
    t_set_sticky;
    t_clear;
    t_collision;
    t_count_irq;
    t_abort_gate;
    t_mode;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule